// File: doc/BRIEF.md
# Separate-Port Burst-of-Four Memory Front End

This block models a memory with a separate write-data input and read-data output. Each rising clock edge samples an active-low read select, an active-low write select and an address. An accepted command moves a burst of four beats. The beats travel two per cycle, one for the rising phase and one for the falling phase. Write beats arrive over the two edges that follow the command. Read beats leave a fixed number of cycles later, and that number is a parameter.

The command rules favour traffic that alternates between reads and writes. After a read, the next cycle ignores the read select. After a write, the next cycle ignores the write select. A steady stream of reads is therefore accepted on every second cycle, and the output bus then carries data with no gap.

When no read burst owns an output cycle, a termination mode input sets what the bus does. The bus either floats or is driven low. The double-rate output is shown as two beat lanes plus a per-cycle drive flag, so no real tri-state buffer is needed. The storage is a small register array held inside the block.

Top module: `sio_burst_sram`

## Requirements
- R1: When the previous cycle accepted no command, `rdSelN`=0 starts a read whatever `wrSelN` is. `wrSelN`=0 with `rdSelN`=1 starts a write. Both high is a NOP. `addr` is sampled only for an accepted command.
- R2: In the cycle after an accepted read, `rdSelN` is ignored. `wrSelN`=0 then starts a write; otherwise the cycle is a NOP.
- R3: In the cycle after an accepted write, `wrSelN` is ignored. `rdSelN`=0 then starts a read; otherwise the cycle is a NOP.
- R4: A write accepted at edge n takes beat 1 from `dinRise` and beat 2 from `dinFall` at edge n+1. It takes beats 3 and 4 from the same lanes at edge n+2, and it stores the four beats at the addressed word. Data on the input lanes at any other edge has no effect.
- R5: A read accepted at edge n sets `qDrive`=1 after edge n+RD_LAT, with beat 1 on `qRise` and beat 2 on `qFall`. After edge n+RD_LAT+1 it puts beats 3 and 4 on the same lanes, still with `qDrive`=1.
- R6: Reads accepted on alternate cycles give output cycles that carry data one after another, with no idle cycle between the bursts.
- R7: A read accepted in the cycle right after a write to the same address returns the four beats of that write.
- R8: In an output cycle owned by no read burst, `termMode`=2'b00 (sampled at the edge that starts the cycle) gives `qDrive`=0 and zero on both lanes, so the bus floats.
- R9: In the same idle cycles, any nonzero `termMode` gives `qDrive`=1 with zero on both lanes, so the bus is driven low.
- R10: While `rstN` is low, `qDrive`=0 and both lanes read zero. Reset leaves every stored word at zero and treats the previous cycle as having accepted no command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands and data are sampled on the rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| rdSelN | input | 1 | Read select, active low |
| wrSelN | input | 1 | Write select, active low |
| addr | input | ADDR_W | Burst address, sampled with an accepted command |
| dinRise | input | BEAT_W | Write beat of the rising phase (beats 1 and 3) |
| dinFall | input | BEAT_W | Write beat of the falling phase (beats 2 and 4) |
| termMode | input | 2 | Idle-bus mode: 00 floats, any other value drives low |
| qRise | output | BEAT_W | Read beat of the rising phase (beats 1 and 3) |
| qFall | output | BEAT_W | Read beat of the falling phase (beats 2 and 4) |
| qDrive | output | 1 | High when the output lanes are driven in this cycle |

## Verification
If the remembered previous command is wrong, a burst is accepted or dropped against the alternation rules. This shows at the ports exactly RD_LAT cycles later, as a data cycle where an idle one was due or the other way round. A wrong read-pipeline stage or a wrong half-burst hold register moves or repeats a half burst. That shows in the first or second output cycle of the burst. A fault in the write address or in the first-half capture shows only when the word is read back, so the bench sweeps every address and reads each one again after each kind of write.

// File: rtl/sio_burst_pkg.sv
package sio_burst_pkg;

  // Command accepted in the previous cycle; drives the alternation rule.
  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } lastOp_e;

  // Strobes from the control block to the datapath, valid for one edge.
  typedef struct packed {
    logic cmdRd;     // read accepted at this edge
    logic cmdWr;     // write accepted at this edge
    logic capFirst;  // take beats 1 and 2 of the pending write
    logic capSecond; // take beats 3 and 4 and store the word
  } ctrlStrobe_t;

endpackage

// File: rtl/sio_burst_ctrl.sv
module sio_burst_ctrl
  import sio_burst_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rdSelN,
  input  logic        wrSelN,
  output ctrlStrobe_t strobe
);

  lastOp_e prevOp;
  logic    capFirstQ;
  logic    capSecondQ;
  logic    rdGo;
  logic    wrGo;

  // Read wins from idle; each select is blocked right after its own kind.
  always_comb begin
    rdGo = !rdSelN && (prevOp != OP_READ);
    wrGo = !wrSelN && (prevOp != OP_WRITE) && !rdGo;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevOp     <= OP_IDLE;
      capFirstQ  <= 1'b0;
      capSecondQ <= 1'b0;
    end else begin
      if (rdGo)      prevOp <= OP_READ;
      else if (wrGo) prevOp <= OP_WRITE;
      else           prevOp <= OP_IDLE;
      capFirstQ  <= wrGo;
      capSecondQ <= capFirstQ;
    end
  end

  always_comb begin
    strobe.cmdRd     = rdGo;
    strobe.cmdWr     = wrGo;
    strobe.capFirst  = capFirstQ;
    strobe.capSecond = capSecondQ;
  end

  // R1: at most one command per edge
  a_r1_single_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.cmdRd, strobe.cmdWr}));

  // R2: no read is accepted in the cycle after a read
  a_r2_read_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdRd |=> !strobe.cmdRd);

  // R3: no write is accepted in the cycle after a write
  a_r3_write_spacing: assert property (@(posedge clk) disable iff (!rstN)
    strobe.cmdWr |=> !strobe.cmdWr);

  // R4: the two capture strobes never overlap
  a_r4_capture_split: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.capFirst && strobe.capSecond));

endmodule

// File: rtl/sio_burst_datapath.sv
module sio_burst_datapath
  import sio_burst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BEAT_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BEAT_W-1:0] dinRise,
  input  logic [BEAT_W-1:0] dinFall,
  input  logic [1:0]        termMode,
  output logic [BEAT_W-1:0] qRise,
  output logic [BEAT_W-1:0] qFall,
  output logic              qDrive
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int BURST = 4;

  typedef logic [BEAT_W-1:0] beat_t;

  beat_t             memArr [DEPTH][BURST];
  logic [ADDR_W-1:0] wrAddrQ;
  beat_t             firstRise;
  beat_t             firstFall;

  logic [RD_LAT-1:0] rdVld;
  logic [ADDR_W-1:0] rdAddr [RD_LAT];
  logic              rdHead;
  logic [ADDR_W-1:0] headAddr;

  beat_t holdRise;
  beat_t holdFall;
  logic  secPend;
  logic  outLive;
  logic  idleDrive;

  // Write capture: address at the command, first half one edge later.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrAddrQ   <= '0;
      firstRise <= '0;
      firstFall <= '0;
    end else begin
      if (strobe.cmdWr)    wrAddrQ <= addr;
      if (strobe.capFirst) begin
        firstRise <= dinRise;
        firstFall <= dinFall;
      end
    end
  end

  // Storage: the whole burst lands when the second half arrives.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int w = 0; w < DEPTH; w++) begin
        for (int b = 0; b < BURST; b++) begin
          memArr[w][b] <= '0;
        end
      end
    end else if (strobe.capSecond) begin
      memArr[wrAddrQ][0] <= firstRise;
      memArr[wrAddrQ][1] <= firstFall;
      memArr[wrAddrQ][2] <= dinRise;
      memArr[wrAddrQ][3] <= dinFall;
    end
  end

  // Read latency pipeline of valid and address.
  for (genvar gi = 0; gi < RD_LAT; gi++) begin : g_rdStage
    if (gi == 0) begin : g_head
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rdVld[gi]  <= 1'b0;
          rdAddr[gi] <= '0;
        end else begin
          rdVld[gi]  <= strobe.cmdRd;
          rdAddr[gi] <= strobe.cmdRd ? addr : rdAddr[gi];
        end
      end
    end else begin : g_tail
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          rdVld[gi]  <= 1'b0;
          rdAddr[gi] <= '0;
        end else begin
          rdVld[gi]  <= rdVld[gi-1];
          rdAddr[gi] <= rdAddr[gi-1];
        end
      end
    end
  end

  always_comb begin
    rdHead    = rdVld[RD_LAT-1];
    headAddr  = rdAddr[RD_LAT-1];
    idleDrive = (termMode != 2'b00);
  end

  // Output lanes: first half, then held second half, else idle pattern.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      qRise    <= '0;
      qFall    <= '0;
      qDrive   <= 1'b0;
      holdRise <= '0;
      holdFall <= '0;
      secPend  <= 1'b0;
      outLive  <= 1'b0;
    end else begin
      outLive <= 1'b1;
      if (rdHead) begin
        qRise    <= memArr[headAddr][0];
        qFall    <= memArr[headAddr][1];
        holdRise <= memArr[headAddr][2];
        holdFall <= memArr[headAddr][3];
        qDrive   <= 1'b1;
        secPend  <= 1'b1;
      end else if (secPend) begin
        qRise   <= holdRise;
        qFall   <= holdFall;
        qDrive  <= 1'b1;
        secPend <= 1'b0;
      end else begin
        qRise  <= '0;
        qFall  <= '0;
        qDrive <= idleDrive;
      end
    end
  end

  // R5: the cycle after a first half always carries the second half
  a_r5_second_half: assert property (@(posedge clk) disable iff (!rstN)
    rdHead |=> (qDrive && secPend));

  // R6: a new burst never collides with a pending second half
  a_r6_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    rdHead |-> !secPend);

  // R8: floating idle cycles only when the mode asked for it
  a_r8_float_idle: assert property (@(posedge clk) disable iff (!rstN)
    (outLive && ($past(termMode) == 2'b00) && !$past(rdHead) && !$past(secPend))
      |-> !qDrive);

  // R9: a nonzero mode keeps the bus driven in every cycle
  a_r9_drive_low: assert property (@(posedge clk) disable iff (!rstN)
    (outLive && ($past(termMode) != 2'b00)) |-> qDrive);

endmodule

// File: rtl/sio_burst_sram.sv
module sio_burst_sram
  import sio_burst_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int BEAT_W = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdSelN,
  input  logic              wrSelN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BEAT_W-1:0] dinRise,
  input  logic [BEAT_W-1:0] dinFall,
  input  logic [1:0]        termMode,
  output logic [BEAT_W-1:0] qRise,
  output logic [BEAT_W-1:0] qFall,
  output logic              qDrive
);

  ctrlStrobe_t strobe;

  sio_burst_ctrl ctrl_i (
    .clk    (clk),
    .rstN   (rstN),
    .rdSelN (rdSelN),
    .wrSelN (wrSelN),
    .strobe (strobe)
  );

  sio_burst_datapath #(
    .ADDR_W (ADDR_W),
    .BEAT_W (BEAT_W),
    .RD_LAT (RD_LAT)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .addr     (addr),
    .dinRise  (dinRise),
    .dinFall  (dinFall),
    .termMode (termMode),
    .qRise    (qRise),
    .qFall    (qFall),
    .qDrive   (qDrive)
  );

endmodule

// File: tb/sio_burst_sram_tb_top.sv
module sio_burst_sram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 4;
  localparam int BW = 8;
  localparam int RL = 2;
  localparam int NADDR = 1 << AW;
  localparam int MAXE = 4096;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          rdSelN = 1'b1;
  logic          wrSelN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [BW-1:0] dinRise = '0;
  logic [BW-1:0] dinFall = '0;
  logic [1:0]    termMode = 2'b00;
  logic [BW-1:0] qRise;
  logic [BW-1:0] qFall;
  logic          qDrive;

  int nCmp = 0;
  int nBad = 0;

  // Reference state, built from the requirements only.
  int       edgeIdx = 0;
  int       prevOp = 0;        // 0 idle, 1 read, 2 write
  bit       isRd [MAXE];
  logic [BW-1:0] expR [MAXE];
  logic [BW-1:0] expF [MAXE];
  bit       fetchAt [MAXE];
  int       fetchAddr [MAXE];
  logic [BW-1:0] mdl [NADDR][4];
  int       wCapEdge = -1;
  int       wComEdge = -1;
  int       wAddr = 0;
  logic [BW-1:0] wB [4];
  string    phase = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  sio_burst_sram #(.ADDR_W(AW), .BEAT_W(BW), .RD_LAT(RL)) dut_i (
    .clk(clk), .rstN(rstN), .rdSelN(rdSelN), .wrSelN(wrSelN), .addr(addr),
    .dinRise(dinRise), .dinFall(dinFall), .termMode(termMode),
    .qRise(qRise), .qFall(qFall), .qDrive(qDrive)
  );

  function automatic logic [BW-1:0] beatVal(int ad, int b, int salt);
    return BW'((ad * 37 + b * 11 + salt * 5 + 1) & 255);
  endfunction

  task automatic compare(string req, logic d, logic [BW-1:0] r, logic [BW-1:0] f,
                         logic ed, logic [BW-1:0] er, logic [BW-1:0] ef);
    nCmp++;
    if (d !== ed || r !== er || f !== ef) begin
      nBad++;
      $display("FAIL %s (phase %s) edge %0d: got drv=%0b rise=%h fall=%h expected drv=%0b rise=%h fall=%h",
               req, phase, edgeIdx, d, r, f, ed, er, ef);
    end
  endtask

  // One clock: drive at negedge, model the edge, check at the next negedge.
  task automatic step(bit rN, bit wN, int ad, int salt);
    int k;
    bit rdOk;
    bit wrOk;
    rdSelN = rN;
    wrSelN = wN;
    addr   = AW'(ad);
    if (wCapEdge == edgeIdx + 1) begin
      dinRise = wB[0]; dinFall = wB[1];
    end else if (wComEdge == edgeIdx + 1) begin
      dinRise = wB[2]; dinFall = wB[3];
    end else begin
      dinRise = BW'(8'hC3 ^ salt); dinFall = BW'(8'h5A + ad);  // must be ignored (R4)
    end
    @(posedge clk);
    edgeIdx++;
    k = edgeIdx;
    if (fetchAt[k]) begin
      isRd[k] = 1'b1;   expR[k] = mdl[fetchAddr[k]][0];   expF[k] = mdl[fetchAddr[k]][1];
      isRd[k+1] = 1'b1; expR[k+1] = mdl[fetchAddr[k]][2]; expF[k+1] = mdl[fetchAddr[k]][3];
    end
    if (wComEdge == k) begin
      for (int b = 0; b < 4; b++) mdl[wAddr][b] = wB[b];
    end
    rdOk = !rN && prevOp != 1;
    wrOk = !wN && prevOp != 2 && !rdOk;
    if (rdOk) begin
      fetchAt[k+RL] = 1'b1;
      fetchAddr[k+RL] = ad;
      prevOp = 1;
    end else if (wrOk) begin
      wAddr = ad;
      for (int b = 0; b < 4; b++) wB[b] = beatVal(ad, b, salt);
      wCapEdge = k + 1;
      wComEdge = k + 2;
      prevOp = 2;
    end else begin
      prevOp = 0;
    end
    @(negedge clk);
    if (isRd[k])
      compare("R5", qDrive, qRise, qFall, 1'b1, expR[k], expF[k]);
    else if (termMode == 2'b00)
      compare("R8", qDrive, qRise, qFall, 1'b0, '0, '0);
    else
      compare("R9", qDrive, qRise, qFall, 1'b1, '0, '0);
  endtask

  task automatic nops(int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b1, i, 90 + i);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog: run did not finish, got hang expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin : main
    for (int w = 0; w < NADDR; w++)
      for (int b = 0; b < 4; b++) mdl[w][b] = '0;

    // R10: reset state, probed with live inputs
    repeat (3) @(negedge clk);
    rdSelN = 1'b0;
    termMode = 2'b01;
    @(negedge clk);
    phase = "R10";
    compare("R10", qDrive, qRise, qFall, 1'b0, '0, '0);
    rdSelN = 1'b1;
    termMode = 2'b00;
    rstN = 1'b1;

    // R1: from idle, both selects low is a read (of a zeroed word)
    phase = "R1";
    step(1'b0, 1'b0, 3, 1);
    nops(4);
    step(1'b1, 1'b0, 5, 2);   // write from idle
    nops(2);
    step(1'b0, 1'b1, 5, 3);   // read it back
    nops(4);

    // R4: write every address, then read every address (R5)
    phase = "R4";
    for (int a = 0; a < NADDR; a++) begin
      step(1'b1, 1'b0, a, 10 + a);
      step(1'b1, 1'b1, a, 0);
    end
    nops(2);
    phase = "R5";
    for (int a = 0; a < NADDR; a++) begin
      step(1'b0, 1'b1, a, 0);
      step(1'b1, 1'b1, a, 0);
    end
    nops(4);

    // R6: read select held low; alternate acceptance, gapless output
    phase = "R6";
    for (int i = 0; i < 2 * NADDR; i++) step(1'b0, 1'b1, (i * 7) & (NADDR - 1), 0);
    nops(4);

    // R2/R3: every pair of select patterns across two cycles
    for (int p = 0; p < 4; p++) begin
      for (int q = 0; q < 4; q++) begin
        if (p[1] == 1'b0)      phase = "R2";
        else if (p[0] == 1'b0) phase = "R3";
        else                   phase = "R1";
        step(p[1], p[0], (p * 4 + q) & (NADDR - 1), 20 + p * 4 + q);
        step(q[1], q[0], (p * 4 + q + 1) & (NADDR - 1), 40 + p * 4 + q);
        nops(4);
      end
    end

    // R7: write then immediate read of the same address
    phase = "R7";
    for (int a = 0; a < NADDR; a++) begin
      step(1'b1, 1'b0, a, 60 + a);
      step(1'b0, 1'b1, a, 0);
      nops(3);
    end

    // R8/R9: idle pattern under every termination mode
    for (int m = 0; m < 4; m++) begin
      termMode = 2'(m);
      phase = (m == 0) ? "R8" : "R9";
      nops(2);
      step(1'b0, 1'b1, m, 0);
      nops(3);
      step(1'b1, 1'b0, m + 4, 70 + m);
      step(1'b0, 1'b1, m + 4, 0);
      nops(4);
    end

    // Final readback of all words after the mixed traffic
    termMode = 2'b10;
    phase = "R4";
    for (int a = 0; a < NADDR; a++) begin
      step(1'b0, 1'b1, a, 0);
      step(1'b1, 1'b1, a, 0);
    end
    nops(4);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

endmodule